// File: doc/BRIEF.md
# Serial Transmit Break and Preamble Sequencer

This block is the character-level control of an asynchronous serial transmitter. It keeps four states (Idle, Ready, sending a data frame, sending a special character) and drives the serial output line from them. From Ready it sends one of three things: an 8N1 data frame, a preamble (a whole character time held high), or a break (a whole character time held low). Every bit boundary advances only on a one-cycle bit-rate tick supplied from outside, so the baud generator is not part of the block.

A held break control makes the block emit break characters back to back with no gap. When the break control drops or the enable is removed, the break in flight is finished and one high stop bit follows, so that a receiver can find the start bit of whatever comes next. Each finished transmission either goes back to Ready (enable still present) or to Idle (enable removed). The two exits differ in how the sticky transfer-complete flag and the commit bit are updated. Preamble and frame requests are single-cycle pulses that stay pending until served. The break control is a level.

Top module: `sertx_sequencer`

## Requirements
- R1: After reset the block is Idle with `txd`=1, `tc_flag`=0 and `commit`=0. In Idle and in Ready the line is held high. Idle moves to Ready on the first clock with `tx_en`=1, and Ready moves back to Idle on the first clock with `tx_en`=0.
- R2: A transmission starts only on a clock where `bit_tick`=1. Each bit lasts from one tick to the next, and `txd` changes only on the clock edge at which `bit_tick` is sampled high.
- R3: A data frame is 10 bit times: one start bit at 0, then the 8 payload bits with bit 0 first, then one stop bit at 1.
- R4: A preamble is 10 bit times at 1. It can only start while `brk_hold`=0.
- R5: A break is 10 bit times at 0. While `brk_hold`=1 and `tx_en`=1 at the tick that ends a break, the next break begins on that same tick, so the line stays low with no gap.
- R6: When a break ends with `brk_hold`=0 or `tx_en`=0, exactly one bit time at 1 follows before anything else is sent.
- R7: When more than one request is pending at a start tick, the order is break first, then preamble, then data frame.
- R8: At the tick that ends a transmission (the final stop bit, or the last preamble bit) with `tx_en`=1, a pending request starts on that same tick and `tc_flag` is left alone. If nothing is pending, the block goes to Ready and sets `tc_flag`.
- R9: If `tx_en` is 0 at the tick that ends a transmission, the block goes to Idle, sets `tc_flag` and clears `commit`. A transmission that is already under way is always sent in full.
- R10: `tc_flag` is sticky. A one-cycle pulse on `tc_clr` clears it, and so does the start of any transmission. A set in the same cycle wins over the clear.
- R11: `commit` is set when any transmission starts. It stays set through the return to Ready and is 0 whenever the block is Idle.
- R12: Preamble and frame request pulses are held as pending at all times, including while disabled. A new frame pulse replaces the payload of a frame that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| tx_en | input | 1 | Transmitter enable |
| brk_hold | input | 1 | Send-break control level |
| pre_pulse | input | 1 | Preamble request pulse |
| frm_pulse | input | 1 | Data frame request pulse |
| frm_data | input | 8 | Payload captured with `frm_pulse` |
| tc_clr | input | 1 | Write-one-to-clear pulse for `tc_flag` |
| txd | output | 1 | Serial output line, high when quiet |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| commit | output | 1 | Transmission commit bit |

## Verification
The assertions check on every cycle that the line is high in Idle and Ready and low for the whole of a break. They also check that the line never moves without a tick, that a stop phase only follows a break, that `commit` is present while sending and absent in Idle, and that every halt into Idle leaves the flag set and the commit bit cleared. The bench scenarios are needed for the rest: the exact bit order of frames, the gap-free repetition of breaks, the stop bit that ends a break sequence, the priority between concurrent requests, and whether the flag is held back when a pending request is served at the end of a transmission. It compares the logged line levels, one per bit time, with sequences computed by its own functions.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    localparam int unsigned TXS_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_DATA  = 2'd2,
        ST_SPEC  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        SP_PRE  = 2'd0,
        SP_BRK  = 2'd1,
        SP_STOP = 2'd2
    } spec_kind_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BRK  = 2'd1,
        SEL_PRE  = 2'd2,
        SEL_DATA = 2'd3
    } req_sel_e;

    typedef struct packed {
        tx_state_e  st;
        spec_kind_e kind;
    } tx_mode_t;

    // Fixed priority among requests: break, preamble, data frame.
    function automatic req_sel_e pick_request(input logic brk, input logic pre, input logic dat);
        req_sel_e s;
        if (brk)      s = SEL_BRK;
        else if (pre) s = SEL_PRE;
        else if (dat) s = SEL_DATA;
        else          s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/txseq_req.sv
module txseq_req #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_set,
    input  logic              frm_set,
    input  logic [DATA_W-1:0] frm_din,
    input  logic              pre_take,
    input  logic              frm_take,
    output logic              pre_pend,
    output logic              frm_pend,
    output logic [DATA_W-1:0] frm_hold
);

    // A new pulse in the same cycle as a take leaves the request pending.
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_pend <= 1'b0;
        end else if (pre_set) begin
            pre_pend <= 1'b1;
        end else if (pre_take) begin
            pre_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_pend <= 1'b0;
            frm_hold <= '0;
        end else if (frm_set) begin
            frm_pend <= 1'b1;
            frm_hold <= frm_din;
        end else if (frm_take) begin
            frm_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/txseq_bitcnt.sv
module txseq_bitcnt #(
    parameter int unsigned CHAR_BITS = 10,
    localparam int unsigned CW = $clog2(CHAR_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    output logic [CW-1:0] idx,
    output logic          last
);

    localparam logic [CW-1:0] LAST_IDX = CW'(CHAR_BITS - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (load) begin
            idx <= '0;
        end else if (adv && !last) begin
            idx <= idx + CW'(1);
        end
    end

endmodule

// File: rtl/txseq_line.sv
module txseq_line
    import txseq_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CHAR_BITS = DATA_W + 2,
    localparam int unsigned CW = $clog2(CHAR_BITS)
) (
    input  tx_mode_t          mode,
    input  logic [CW-1:0]     idx,
    input  logic [DATA_W-1:0] data,
    output logic              txd
);

    localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W);

    logic [DATA_W-1:0] shifted;

    assign shifted = data >> (idx - CW'(1));

    always_comb begin
        txd = 1'b1;
        case (mode.st)
            ST_DATA: begin
                if (idx == '0)             txd = 1'b0;
                else if (idx <= LAST_DATA) txd = shifted[0];
                else                       txd = 1'b1;
            end
            ST_SPEC: txd = (mode.kind == SP_BRK) ? 1'b0 : 1'b1;
            default: txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer
    import txseq_pkg::*;
#(
    parameter int unsigned DATA_W = TXS_DATA_W,
    localparam int unsigned CHAR_BITS = DATA_W + 2,
    localparam int unsigned CW = $clog2(CHAR_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_hold,
    input  logic              pre_pulse,
    input  logic              frm_pulse,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              tc_clr,
    output logic              txd,
    output logic              tc_flag,
    output logic              commit
);

    tx_mode_t          mode_q, mode_d;
    logic [DATA_W-1:0] data_q;
    logic              tc_q, cmt_q;
    logic              pre_pend, frm_pend;
    logic [DATA_W-1:0] frm_hold;
    logic [CW-1:0]     idx;
    logic              last;
    req_sel_e          sel;
    logic              start, done_ok, halt;
    logic              char_end, stop_end;

    assign sel = pick_request(brk_hold, pre_pend, frm_pend);

    txseq_req #(.DATA_W(DATA_W)) u_req (
        .clk      (clk),
        .rst      (rst),
        .pre_set  (pre_pulse),
        .frm_set  (frm_pulse),
        .frm_din  (frm_data),
        .pre_take (start && (sel == SEL_PRE)),
        .frm_take (start && (sel == SEL_DATA)),
        .pre_pend (pre_pend),
        .frm_pend (frm_pend),
        .frm_hold (frm_hold)
    );

    txseq_bitcnt #(.CHAR_BITS(CHAR_BITS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .adv  (bit_tick),
        .idx  (idx),
        .last (last)
    );

    txseq_line #(.DATA_W(DATA_W), .CHAR_BITS(CHAR_BITS)) u_line (
        .mode (mode_q),
        .idx  (idx),
        .data (data_q),
        .txd  (txd)
    );

    // End of a full character (data, preamble or break) and end of the trailing stop bit.
    assign char_end = bit_tick && last &&
                      ((mode_q.st == ST_DATA) ||
                       ((mode_q.st == ST_SPEC) && (mode_q.kind != SP_STOP)));
    assign stop_end = bit_tick && (mode_q.st == ST_SPEC) && (mode_q.kind == SP_STOP);

    always_comb begin
        mode_d  = mode_q;
        start   = 1'b0;
        done_ok = 1'b0;
        halt    = 1'b0;
        case (mode_q.st)
            ST_IDLE: begin
                if (tx_en) mode_d.st = ST_READY;
            end
            ST_READY: begin
                if (!tx_en)                            mode_d.st = ST_IDLE;
                else if (bit_tick && sel != SEL_NONE)  start = 1'b1;
            end
            default: begin
                if (mode_q.st == ST_SPEC && mode_q.kind == SP_BRK && char_end) begin
                    // Repeat the break while held, else close the sequence with a stop bit.
                    if (tx_en && brk_hold) start = 1'b1;
                    else                   mode_d.kind = SP_STOP;
                end else if (char_end || stop_end) begin
                    if (!tx_en) begin
                        halt      = 1'b1;
                        mode_d.st = ST_IDLE;
                    end else if (sel != SEL_NONE) begin
                        start = 1'b1;
                    end else begin
                        done_ok   = 1'b1;
                        mode_d.st = ST_READY;
                    end
                end
            end
        endcase
        if (start) begin
            case (sel)
                SEL_BRK:  mode_d = '{st: ST_SPEC, kind: SP_BRK};
                SEL_PRE:  mode_d = '{st: ST_SPEC, kind: SP_PRE};
                default:  mode_d = '{st: ST_DATA, kind: SP_PRE};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{st: ST_IDLE, kind: SP_PRE};
            data_q <= '0;
            tc_q   <= 1'b0;
            cmt_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (start && sel == SEL_DATA) data_q <= frm_hold;
            if (done_ok || halt)          tc_q <= 1'b1;
            else if (start || tc_clr)     tc_q <= 1'b0;
            if (start)                    cmt_q <= 1'b1;
            else if (mode_d.st == ST_IDLE) cmt_q <= 1'b0;
        end
    end

    assign tc_flag = tc_q;
    assign commit  = cmt_q;

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk
    import txseq_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     bit_tick,
    input logic     txd,
    input logic     tc_flag,
    input logic     commit,
    input tx_mode_t mode
);

    a_r1_quiet_line_high: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_IDLE || mode.st == ST_READY) |-> txd);

    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd));

    a_r5_break_low: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_SPEC && mode.kind == SP_BRK) |-> !txd);

    a_r6_stop_high: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_SPEC && mode.kind == SP_STOP) |-> txd);

    a_r6_stop_after_break: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_SPEC && mode.kind == SP_STOP) |->
        ($past(mode.st) == ST_SPEC && $past(mode.kind) != SP_PRE));

    a_r9_halt_flags: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_IDLE && ($past(mode.st) == ST_DATA || $past(mode.st) == ST_SPEC))
        |-> (tc_flag && !commit));

    a_r11_commit_when_busy: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_DATA || mode.st == ST_SPEC) |-> commit);

    a_r11_no_commit_idle: assert property (@(posedge clk) disable iff (rst)
        (mode.st == ST_IDLE) |-> !commit);

endmodule

bind sertx_sequencer txseq_chk u_txseq_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .txd      (txd),
    .tc_flag  (tc_flag),
    .commit   (commit),
    .mode     (mode_q)
);

// File: tb/test_sertx_sequencer.sv
module test_sertx_sequencer;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_hold = 1'b0;
    logic       pre_pulse = 1'b0;
    logic       frm_pulse = 1'b0;
    logic [7:0] frm_data = 8'h00;
    logic       tc_clr = 1'b0;
    logic       txd, tc_flag, commit;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic lg [0:255];
    int   nlg = 0;
    bit   logging = 0;
    logic ex [0:255];
    int   nex = 0;

    sertx_sequencer i_sertx_sequencer (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .brk_hold(brk_hold),
        .pre_pulse(pre_pulse), .frm_pulse(frm_pulse), .frm_data(frm_data), .tc_clr(tc_clr),
        .txd(txd), .tc_flag(tc_flag), .commit(commit)
    );

    initial forever #4 clk = ~clk;

    // Tick generator: one cycle high every DIV cycles, changed at the falling edge.
    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % DIV;
            bit_tick = (tcnt == 0);
        end
    end

    // Line monitor: one sample per bit, shortly after each tick edge.
    initial begin
        logic tk;
        forever begin
            @(posedge clk);
            tk = bit_tick;
            #1;
            if (tk && logging && nlg < 256) begin
                lg[nlg] = txd;
                nlg++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sync_tick();
        @(posedge clk iff bit_tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) sync_tick();
    endtask

    task automatic ex_lvl(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            ex[nex] = v;
            nex++;
        end
    endtask

    // 8N1 frame, bit 0 of the payload first.
    task automatic ex_frame(input logic [7:0] d);
        ex_lvl(1'b0, 1);
        for (int i = 0; i < 8; i++) ex_lvl(d[i], 1);
        ex_lvl(1'b1, 1);
    endtask

    task automatic begin_seq(input logic en);
        sync_tick();
        nlg = 0;
        nex = 0;
        logging = 1;
        tx_en = en;
    endtask

    task automatic pulse_frm(input logic [7:0] d);
        frm_data = d;
        frm_pulse = 1'b1;
        @(negedge clk);
        frm_pulse = 1'b0;
    endtask

    task automatic pulse_pre();
        pre_pulse = 1'b1;
        @(negedge clk);
        pre_pulse = 1'b0;
    endtask

    task automatic cmp_log(input string tag);
        int bad_at;
        while (nlg < nex) @(negedge clk);
        logging = 0;
        bad_at = -1;
        for (int i = nex - 1; i >= 0; i--) if (lg[i] !== ex[i]) bad_at = i;
        if (bad_at < 0) chk(1'b1, tag, 0, 0);
        else begin
            $display("  sequence %s differs at bit %0d", tag, bad_at);
            chk(1'b0, tag, int'(lg[bad_at]), int'(ex[bad_at]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d1, d2;
        bit btb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        chk(tc_flag == 1'b0, "R1 reset tc_flag", int'(tc_flag), 0);
        chk(commit == 1'b0, "R1 reset commit", int'(commit), 0);
        rst = 1'b0;

        // R12: requests while disabled are held; the later frame replaces the earlier one
        begin_seq(1'b0);
        pulse_frm(8'h11);
        pulse_frm(8'h22);
        ex_lvl(1'b1, 4);
        cmp_log("R12 disabled line stays high");
        begin_seq(1'b1);
        ex_frame(8'h22);
        ex_lvl(1'b1, 2);
        cmp_log("R12 replaced frame sent after enable");
        chk(commit == 1'b1, "R11 commit kept after done", int'(commit), 1);
        chk(tc_flag == 1'b1, "R8 tc set when nothing pending", int'(tc_flag), 1);

        // R2 / R3 / R10: start waits for tick, start clears tc
        begin_seq(1'b1);
        pulse_frm(8'h3C);
        chk(txd == 1'b1, "R2 no start before tick", int'(txd), 1);
        ex_frame(8'h3C);
        ex_lvl(1'b1, 2);
        wait_ticks(1);
        chk(tc_flag == 1'b0, "R10 start clears tc", int'(tc_flag), 0);
        cmp_log("R3 frame 3C");
        chk(tc_flag == 1'b1, "R8 tc after frame", int'(tc_flag), 1);

        // R10 clear pulse
        tc_clr = 1'b1;
        @(negedge clk);
        tc_clr = 1'b0;
        chk(tc_flag == 1'b0, "R10 tc_clr clears", int'(tc_flag), 0);
        chk(txd == 1'b1, "R1 ready line high", int'(txd), 1);

        // R3 / R8 random frames, some back to back
        for (int k = 0; k < 8; k++) begin
            d1 = 8'($urandom);
            d2 = 8'($urandom);
            btb = 1'($urandom);
            begin_seq(1'b1);
            pulse_frm(d1);
            ex_frame(d1);
            if (btb) begin
                wait_ticks(5);
                pulse_frm(d2);
                ex_frame(d2);
            end
            ex_lvl(1'b1, 2);
            cmp_log(btb ? "R8 back-to-back frames" : "R3 random frame");
        end

        // R4 / R7: preamble before data
        begin_seq(1'b1);
        pulse_pre();
        pulse_frm(8'h5A);
        ex_lvl(1'b1, 10);
        ex_frame(8'h5A);
        ex_lvl(1'b1, 2);
        wait_ticks(4);
        chk(tc_flag == 1'b0, "R4 preamble in progress", int'(tc_flag), 0);
        chk(commit == 1'b1, "R11 commit during preamble", int'(commit), 1);
        cmp_log("R7 preamble then frame");

        // R5 / R6 / R7 / R8: repeated breaks, stop bit, then pending preamble
        begin_seq(1'b1);
        brk_hold = 1'b1;
        pulse_pre();
        wait_ticks(24);
        brk_hold = 1'b0;
        ex_lvl(1'b0, 30);
        ex_lvl(1'b1, 1);
        ex_lvl(1'b1, 12);
        wait_ticks(10);
        chk(tc_flag == 1'b0, "R8 pending preamble holds tc", int'(tc_flag), 0);
        cmp_log("R5 repeated breaks with stop");
        chk(tc_flag == 1'b1, "R8 tc after preamble", int'(tc_flag), 1);

        // R9: disable during a data frame
        begin_seq(1'b1);
        pulse_frm(8'hC3);
        wait_ticks(3);
        tx_en = 1'b0;
        ex_frame(8'hC3);
        ex_lvl(1'b1, 3);
        cmp_log("R9 frame finished after disable");
        chk(tc_flag == 1'b1, "R9 halt sets tc", int'(tc_flag), 1);
        chk(commit == 1'b0, "R9 halt clears commit", int'(commit), 0);

        // R9 / R6: disable during a held break
        begin_seq(1'b1);
        brk_hold = 1'b1;
        wait_ticks(3);
        tx_en = 1'b0;
        ex_lvl(1'b0, 10);
        ex_lvl(1'b1, 5);
        cmp_log("R6 break halted with stop bit");
        chk(tc_flag == 1'b1, "R9 break halt tc", int'(tc_flag), 1);
        chk(commit == 1'b0, "R9 break halt commit", int'(commit), 0);
        brk_hold = 1'b0;

        // R6 / R7: break first, stop bit, then pending frame
        begin_seq(1'b1);
        brk_hold = 1'b1;
        pulse_frm(8'h96);
        wait_ticks(5);
        brk_hold = 1'b0;
        ex_lvl(1'b0, 10);
        ex_lvl(1'b1, 1);
        ex_frame(8'h96);
        ex_lvl(1'b1, 2);
        cmp_log("R6 stop bit before frame");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule